// File: doc/BRIEF.md
# Time-of-Day Watch with Alarm

This block keeps a time of day in hours, minutes and seconds and holds a separate alarm time. A host loads either time one field at a time through a byte-wide write port with a three-bit address. A one-second tick input, produced elsewhere, moves the watch forward, with seconds carrying into minutes and minutes into hours, and the day wrapping at midnight.

Written values are cut down to the width of their field. A watch-hours value above 23 is held at 23. An alarm-hours value is stored as given even when it is out of range. The alarm is armed only while every stored alarm field is a legal time, so an impossible alarm time turns the alarm off. The reset values leave it off.

Whenever a tick moves the watch onto the armed alarm time, the block emits a pulse that lasts one clock. Both times and the armed flag are visible on output ports.

Top module: `tod_alarm_watch`

## Requirements
- R1: After reset the watch reads 0:00:00, the alarm reads hours 31, minutes 63, seconds 63, `alarm_armed_o` is 0 and `alarm_hit_o` is 0.
- R2: With `wr_en_i` high, address 2 writes alarm hours, 3 alarm minutes, 4 alarm seconds, 5 watch hours, 6 watch minutes and 7 watch seconds. Addresses 0 and 1, and any cycle with `wr_en_i` low, change nothing.
- R3: An hours write keeps data bits 4..0 and a minutes or seconds write keeps data bits 5..0. For example, 70 stores 6 and 81 stores 17.
- R4: A watch-hours write whose masked value is above 23 stores 23.
- R5: An alarm-hours write stores the masked value unchanged even when it is above 23.
- R6: `alarm_armed_o` is 1 exactly when alarm hours ≤ 23, alarm minutes ≤ 59 and alarm seconds ≤ 59.
- R7: Each tick that is applied adds one second. Seconds go from 59 to 0 and carry into minutes, minutes go from 59 to 0 and carry into hours, and hours go from 23 to 0.
- R8: A watch minutes or seconds value from 60 to 63 stays as written. The next carry into that field, or the next tick for seconds, sets it to 0 and carries on.
- R9: `alarm_hit_o` is high for exactly one clock, starting at the clock edge where an applied tick makes the watch equal the alarm while the alarm is armed. It never goes high while the alarm is disarmed.
- R10: A watch-field write in the same cycle as a tick takes effect, and that tick is dropped. An alarm-field write does not block a tick.
- R11: When there is no tick and no write, the watch and the alarm keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| tick_i | input | 1 | One-second advance strobe, one clock wide |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register address |
| wr_data_i | input | 8 | Write data |
| watch_hr_o | output | 5 | Watch hours |
| watch_min_o | output | 6 | Watch minutes |
| watch_sec_o | output | 6 | Watch seconds |
| alarm_hr_o | output | 5 | Alarm hours |
| alarm_min_o | output | 6 | Alarm minutes |
| alarm_sec_o | output | 6 | Alarm seconds |
| alarm_armed_o | output | 1 | Alarm time is a legal time |
| alarm_hit_o | output | 1 | One-clock alarm match pulse |

## Verification
A corrupted watch field shows up on the watch outputs at the clock edge that follows the bad write or tick. A wrong carry only shows up at the tick that crosses a 59 or 23 boundary, so the directed cases sit just below those edges and also start from over-range minutes and seconds. A fault in the comparison or in the armed decode shows up on `alarm_hit_o` in the same cycle as the matching tick: either no pulse, a pulse two clocks long, or a pulse while the alarm is disarmed with equal fields. That last case is built on purpose using minutes of 60.

// File: rtl/tod_pkg.sv
package tod_pkg;
  parameter int ADDR_W = 3;
  parameter int DATA_W = 8;
  parameter int HR_W   = 5;
  parameter int MS_W   = 6;
  parameter int HR_MAX = 23;
  parameter int MS_MAX = 59;

  parameter logic [ADDR_W-1:0] ADR_ALM_HR  = 3'd2;
  parameter logic [ADDR_W-1:0] ADR_ALM_MIN = 3'd3;
  parameter logic [ADDR_W-1:0] ADR_ALM_SEC = 3'd4;
  parameter logic [ADDR_W-1:0] ADR_WCH_HR  = 3'd5;
  parameter logic [ADDR_W-1:0] ADR_WCH_MIN = 3'd6;
  parameter logic [ADDR_W-1:0] ADR_WCH_SEC = 3'd7;

  typedef struct packed {
    logic [HR_W-1:0] hr;
    logic [MS_W-1:0] min;
    logic [MS_W-1:0] sec;
  } tod_t;

  localparam tod_t ALARM_RST = '{hr: '1, min: '1, sec: '1};
  localparam tod_t WATCH_RST = '{hr: '0, min: '0, sec: '0};
endpackage

// File: rtl/tod_rst_sync.sv
module tod_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) sync_q <= '0;
    else          sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = sync_q[STAGES-1];
endmodule

// File: rtl/tod_alarm_regs.sv
module tod_alarm_regs
  import tod_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output tod_t              alarm_o,
  output logic              armed_o
);
  tod_t alarm_q, alarm_d;
  logic load;

  always_comb begin
    alarm_d = alarm_q;
    load    = 1'b0;
    if (wr_en_i) begin
      unique case (wr_addr_i)
        ADR_ALM_HR:  begin alarm_d.hr  = wr_data_i[HR_W-1:0]; load = 1'b1; end
        ADR_ALM_MIN: begin alarm_d.min = wr_data_i[MS_W-1:0]; load = 1'b1; end
        ADR_ALM_SEC: begin alarm_d.sec = wr_data_i[MS_W-1:0]; load = 1'b1; end
        default:     load = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    alarm_q <= ALARM_RST;
    else if (load) alarm_q <= alarm_d;
  end

  assign alarm_o = alarm_q;
  assign armed_o = (alarm_q.hr  <= HR_W'(HR_MAX)) &&
                   (alarm_q.min <= MS_W'(MS_MAX)) &&
                   (alarm_q.sec <= MS_W'(MS_MAX));

  AST_ALM_HR_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_addr_i == ADR_ALM_HR) |=> alarm_q.hr == $past(wr_data_i[HR_W-1:0])); // R5
  AST_ALM_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en_i |=> $stable(alarm_q)); // R11
endmodule

// File: rtl/tod_watch_ctr.sv
module tod_watch_ctr
  import tod_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output tod_t              watch_o,
  output tod_t              watch_next_o,
  output logic              advance_o
);
  tod_t watch_q, watch_d;
  logic host_wr, advance, load;
  logic sec_wrap, min_wrap;
  logic [HR_W-1:0] hr_in;

  assign host_wr = wr_en_i && (wr_addr_i == ADR_WCH_HR ||
                               wr_addr_i == ADR_WCH_MIN ||
                               wr_addr_i == ADR_WCH_SEC);
  assign advance = tick_i && !host_wr;
  assign load    = host_wr || advance;
  assign hr_in   = wr_data_i[HR_W-1:0];

  assign sec_wrap = watch_q.sec >= MS_W'(MS_MAX);
  assign min_wrap = watch_q.min >= MS_W'(MS_MAX);

  always_comb begin
    watch_d = watch_q;
    if (host_wr) begin
      unique case (wr_addr_i)
        ADR_WCH_HR:  watch_d.hr  = (hr_in > HR_W'(HR_MAX)) ? HR_W'(HR_MAX) : hr_in;
        ADR_WCH_MIN: watch_d.min = wr_data_i[MS_W-1:0];
        default:     watch_d.sec = wr_data_i[MS_W-1:0];
      endcase
    end else if (advance) begin
      watch_d.sec = sec_wrap ? '0 : watch_q.sec + 1'b1;
      if (sec_wrap) begin
        watch_d.min = min_wrap ? '0 : watch_q.min + 1'b1;
        if (min_wrap)
          watch_d.hr = (watch_q.hr >= HR_W'(HR_MAX)) ? '0 : watch_q.hr + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    watch_q <= WATCH_RST;
    else if (load) watch_q <= watch_d;
  end

  assign watch_o      = watch_q;
  assign watch_next_o = watch_d;
  assign advance_o    = advance;

  AST_HR_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    watch_q.hr <= HR_W'(HR_MAX)); // R4
  AST_SEC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !wr_en_i && watch_q.sec == MS_W'(MS_MAX)) |=> watch_q.sec == '0); // R7
  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && wr_en_i && wr_addr_i == ADR_WCH_SEC) |=> watch_q.sec == $past(wr_data_i[MS_W-1:0])); // R10
  AST_WATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !wr_en_i) |=> $stable(watch_q)); // R11
endmodule

// File: rtl/tod_alarm_match.sv
module tod_alarm_match
  import tod_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic advance_i,
  input  logic armed_i,
  input  tod_t watch_next_i,
  input  tod_t alarm_i,
  output logic hit_o
);
  logic hit_q, hit_d;

  assign hit_d = advance_i && armed_i && (watch_next_i == alarm_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hit_q <= 1'b0;
    else        hit_q <= hit_d;
  end

  assign hit_o = hit_q;

  AST_HIT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    hit_q |=> !hit_q); // R9
  AST_HIT_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    hit_q |-> $past(armed_i)); // R9
endmodule

// File: rtl/tod_alarm_watch.sv
module tod_alarm_watch
  import tod_pkg::*;
#(
  parameter int RST_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [HR_W-1:0]   watch_hr_o,
  output logic [MS_W-1:0]   watch_min_o,
  output logic [MS_W-1:0]   watch_sec_o,
  output logic [HR_W-1:0]   alarm_hr_o,
  output logic [MS_W-1:0]   alarm_min_o,
  output logic [MS_W-1:0]   alarm_sec_o,
  output logic              alarm_armed_o,
  output logic              alarm_hit_o
);
  logic rst_sync_n;
  tod_t alarm, watch, watch_next;
  logic armed, advance, hit;

  tod_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (rst_sync_n)
  );

  tod_alarm_regs u_alarm (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .alarm_o   (alarm),
    .armed_o   (armed)
  );

  tod_watch_ctr u_watch (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .tick_i       (tick_i),
    .wr_en_i      (wr_en_i),
    .wr_addr_i    (wr_addr_i),
    .wr_data_i    (wr_data_i),
    .watch_o      (watch),
    .watch_next_o (watch_next),
    .advance_o    (advance)
  );

  tod_alarm_match u_match (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .advance_i    (advance),
    .armed_i      (armed),
    .watch_next_i (watch_next),
    .alarm_i      (alarm),
    .hit_o        (hit)
  );

  assign watch_hr_o    = watch.hr;
  assign watch_min_o   = watch.min;
  assign watch_sec_o   = watch.sec;
  assign alarm_hr_o    = alarm.hr;
  assign alarm_min_o   = alarm.min;
  assign alarm_sec_o   = alarm.sec;
  assign alarm_armed_o = armed;
  assign alarm_hit_o   = hit;

  AST_HIT_EQUAL: assert property (@(posedge clk) disable iff (!rst_sync_n)
    hit |-> (watch == $past(alarm))); // R9
  AST_DISARM_RANGE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (alarm.hr > HR_W'(HR_MAX)) |-> !armed); // R6
endmodule

// File: tb/sim_tod_alarm_watch.sv
module sim_tod_alarm_watch;
  logic clk = 1'b0;
  logic rst_n;
  logic tick, we;
  logic [2:0] addr;
  logic [7:0] data;
  logic [4:0] w_hr, a_hr;
  logic [5:0] w_min, w_sec, a_min, a_sec;
  logic armed, hit;
  int checks = 0;
  int fails = 0;

  always #5 clk = ~clk;

  tod_alarm_watch u0 (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .wr_en_i(we),
    .wr_addr_i(addr), .wr_data_i(data),
    .watch_hr_o(w_hr), .watch_min_o(w_min), .watch_sec_o(w_sec),
    .alarm_hr_o(a_hr), .alarm_min_o(a_min), .alarm_sec_o(a_sec),
    .alarm_armed_o(armed), .alarm_hit_o(hit)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_watch(input string req, input int h, input int m, input int s);
    chk({req, " watch hr"}, w_hr, h);
    chk({req, " watch min"}, w_min, m);
    chk({req, " watch sec"}, w_sec, s);
  endtask

  task automatic chk_alarm(input string req, input int h, input int m, input int s);
    chk({req, " alarm hr"}, a_hr, h);
    chk({req, " alarm min"}, a_min, m);
    chk({req, " alarm sec"}, a_sec, s);
  endtask

  // One clock of stimulus: drive at negedge, return at the next negedge.
  task automatic cyc(input logic t, input logic w, input int a, input int d);
    tick = t; we = w; addr = 3'(a); data = 8'(d);
    @(negedge clk);
    tick = 1'b0; we = 1'b0; addr = '0; data = '0;
  endtask

  task automatic wr(input int a, input int d);
    cyc(1'b0, 1'b1, a, d);
  endtask

  task automatic set_watch(input int h, input int m, input int s);
    wr(5, h); wr(6, m); wr(7, s);
  endtask

  task automatic set_alarm(input int h, input int m, input int s);
    wr(2, h); wr(3, m); wr(4, s);
  endtask

  task automatic t_reset;
    chk_watch("R1", 0, 0, 0);
    chk_alarm("R1", 31, 63, 63);
    chk("R1 armed", armed, 0);
    chk("R1 hit", hit, 0);
  endtask

  task automatic t_addr_map;
    set_watch(10, 20, 30);
    chk_watch("R2 map", 10, 20, 30);
    wr(0, 5); wr(1, 7);
    chk_watch("R2 addr0/1 ignored", 10, 20, 30);
    chk_alarm("R2 addr0/1 ignored", 31, 63, 63);
    cyc(1'b0, 1'b0, 5, 3);
    cyc(1'b0, 1'b0, 2, 3);
    chk_watch("R2 wr_en low", 10, 20, 30);
    chk_alarm("R2 wr_en low", 31, 63, 63);
  endtask

  task automatic t_mask;
    wr(6, 70); wr(7, 81);
    chk("R3 watch min 70", w_min, 6);
    chk("R3 watch sec 81", w_sec, 17);
    wr(5, 44);
    chk("R3 watch hr 44", w_hr, 12);
    wr(3, 70); wr(4, 81); wr(2, 229);
    chk_alarm("R3 alarm mask", 5, 6, 17);
    chk("R6 armed legal", armed, 1);
  endtask

  task automatic t_clamp;
    wr(5, 25);
    chk("R4 watch hr 25", w_hr, 23);
    wr(5, 31);
    chk("R4 watch hr 31", w_hr, 23);
    wr(2, 25);
    chk("R5 alarm hr 25", a_hr, 25);
    chk("R6 armed hr 25", armed, 0);
  endtask

  task automatic t_armed;
    set_alarm(10, 6, 17);
    chk("R6 armed", armed, 1);
    wr(3, 60);
    chk("R6 min 60", armed, 0);
    wr(3, 59); wr(4, 60);
    chk("R6 sec 60", armed, 0);
    wr(4, 59); wr(2, 23);
    chk("R6 23:59:59", armed, 1);
    wr(2, 24);
    chk("R6 hr 24", armed, 0);
  endtask

  task automatic t_roll;
    set_watch(23, 59, 58);
    cyc(1'b1, 1'b0, 0, 0);
    chk_watch("R7 tick", 23, 59, 59);
    cyc(1'b1, 1'b0, 0, 0);
    chk_watch("R7 midnight", 0, 0, 0);
    set_watch(4, 10, 59);
    cyc(1'b1, 1'b0, 0, 0);
    chk_watch("R7 sec carry", 4, 11, 0);
    set_watch(7, 59, 59);
    cyc(1'b1, 1'b0, 0, 0);
    chk_watch("R7 min carry", 8, 0, 0);
  endtask

  task automatic t_overrange;
    set_watch(3, 62, 63);
    chk_watch("R8 stored", 3, 62, 63);
    cyc(1'b1, 1'b0, 0, 0);
    chk_watch("R8 double wrap", 4, 0, 0);
    set_watch(3, 10, 60);
    cyc(1'b1, 1'b0, 0, 0);
    chk_watch("R8 sec 60", 3, 11, 0);
  endtask

  task automatic t_match;
    set_alarm(10, 6, 17);
    set_watch(10, 6, 16);
    chk("R9 no hit before", hit, 0);
    cyc(1'b1, 1'b0, 0, 0);
    chk("R9 hit on match", hit, 1);
    chk_watch("R9 match time", 10, 6, 17);
    cyc(1'b0, 1'b0, 0, 0);
    chk("R9 hit one cycle", hit, 0);
    cyc(1'b1, 1'b0, 0, 0);
    chk("R9 no hit past", hit, 0);
    set_alarm(0, 0, 0);
    set_watch(23, 59, 59);
    cyc(1'b1, 1'b0, 0, 0);
    chk("R9 hit midnight", hit, 1);
    cyc(1'b0, 1'b0, 0, 0);
    chk("R9 midnight one cycle", hit, 0);
    set_alarm(10, 60, 5);
    set_watch(10, 60, 4);
    cyc(1'b1, 1'b0, 0, 0);
    chk_watch("R9 disarmed time", 10, 60, 5);
    chk("R9 disarmed no hit", hit, 0);
    chk("R6 disarmed min 60", armed, 0);
  endtask

  task automatic t_priority;
    set_watch(1, 2, 3);
    cyc(1'b1, 1'b1, 7, 40);
    chk_watch("R10 sec write wins", 1, 2, 40);
    cyc(1'b1, 1'b1, 6, 9);
    chk_watch("R10 min write drops tick", 1, 9, 40);
    cyc(1'b1, 1'b1, 4, 0);
    chk_watch("R10 alarm write keeps tick", 1, 9, 41);
    chk("R10 alarm sec", a_sec, 0);
  endtask

  task automatic t_hold;
    set_watch(12, 34, 56);
    set_alarm(1, 2, 3);
    for (int i = 0; i < 5; i++) cyc(1'b0, 1'b0, 0, 0);
    chk_watch("R11 hold", 12, 34, 56);
    chk_alarm("R11 hold", 1, 2, 3);
    chk("R11 hit quiet", hit, 0);
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; tick = 1'b0; we = 1'b0; addr = '0; data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_addr_map();
    t_mask();
    t_clamp();
    t_armed();
    t_roll();
    t_overrange();
    t_match();
    t_priority();
    t_hold();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule